// File: doc/BRIEF.md
# Non-Maskable Flag Register Bank for Extended Private Interrupts

This block holds one non-maskable flag per extended private peripheral interrupt of a redistributor, in a small bank of 32-bit memory-mapped words. Software reads and writes the words over a simple register bus. The bus carries an address, a write enable, a read strobe, write data and a flag that marks the access as secure. The bank drives the resulting per-interrupt non-maskable vector to the prioritisation logic.

A stored flag only counts while its interrupt is eligible. An interrupt is eligible when the feature is present, the interrupt is implemented, it is not Group 0, and affinity routing is enabled for its security state. An access sees or changes a bit only when the interrupt is eligible and the access's security allows it. Bits outside that set read as zero and ignore writes. A stored flag is kept while its interrupt is masked, and it counts again once the mask lifts. Every flag changes at a single clock edge, so a pending interrupt sees either the old or the new value and never a mixture.

Top module: `nmi_prop_regs`

## Requirements
- R1: After reset every stored flag is 0, `nmi_out` is all zero and `rd_data` is zero.
- R2: Word k (k = 0, 1) sits at byte offset 0xF80 + 4k, with address bits [1:0] ignored. Its bit x is the flag of interrupt 32k + x and drives `nmi_out[32k+x]`. A value of 1 means non-maskable. Reads and writes to any other offset return zero and change no flag.
- R3: `rd_data` carries the read value in the cycle after a read strobe and is zero in the cycle after any cycle without one. A read and a write to the same word in the same cycle return the value from before the write.
- R4: While `feat_en` is 0, all words read as zero, writes change no flag and `nmi_out` is zero.
- R5: `impl_cnt` sets how many interrupts exist: 0 gives none, 1 gives interrupts 0–31, and 2 or more gives 0–63. Bits of interrupts that do not exist read as zero, ignore writes and are zero on `nmi_out`.
- R6: An interrupt is Group 0 when `grp[i]`=0 and either `grp_mod[i]`=0 or `sec_dis`=1. Its bit reads as zero, cannot be set and is zero on `nmi_out`.
- R7: With `sec_dis`=0, an interrupt with `grp[i]`=0 and `grp_mod[i]`=1 is secure Group 1. A non-secure access (`bus_secure`=0) reads its bit as zero and cannot change it. A secure access reads and writes it normally.
- R8: With `sec_dis`=0, interrupts with `grp[i]`=0 follow `aff_en_s` and those with `grp[i]`=1 follow `aff_en_ns`. With `sec_dis`=1, all interrupts follow `aff_en_s`. While the governing enable is 0, the bit reads as zero, ignores writes and is zero on `nmi_out`.
- R9: `nmi_out` is the stored flag ANDed with eligibility, and it follows input changes in the same cycle. A flag kept while masked reappears once the mask is lifted. An accepted write shows on `nmi_out` right after the clock edge that takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte offset in the register frame |
| bus_wr | input | 1 | Write enable |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_secure | input | 1 | 1 when the access is secure |
| rd_data | output | 32 | Registered read data |
| feat_en | input | 1 | Non-maskable feature present |
| impl_cnt | input | 4 | Implemented extended interrupt count code |
| sec_dis | input | 1 | Single security state when 1 |
| aff_en_s | input | 1 | Affinity routing enable, secure state |
| aff_en_ns | input | 1 | Affinity routing enable, non-secure state |
| grp | input | 64 | Per-interrupt group bit |
| grp_mod | input | 64 | Per-interrupt group modifier bit |
| nmi_out | output | 64 | Effective non-maskable vector |

## Verification
The hardest case to reach from the ports is a flag that is stored but hidden. One example is a secure Group 1 bit set by a secure write, which must then survive a non-secure write of zero to the same word. Another is a flag held while `sec_dis` or an affinity enable masks it, which must return unchanged when the mask lifts. The stimulus sets the flags first, then changes the group, security and routing inputs around a write. It then reads the word back with both access securities and compares `nmi_out` at each step, so a write that leaked through a mask shows up as a wrong word.

// File: rtl/nmi_prop_regs.sv
module nmi_prop_regs #(
  parameter int NREG = 2,
  parameter int AW = 12,
  parameter logic [AW-1:0] BASE_ADDR = 12'hF80
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AW-1:0]        bus_addr,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [31:0]          bus_wdata,
  input  logic                 bus_secure,
  output logic [31:0]          rd_data,
  input  logic                 feat_en,
  input  logic [3:0]           impl_cnt,
  input  logic                 sec_dis,
  input  logic                 aff_en_s,
  input  logic                 aff_en_ns,
  input  logic [32*NREG-1:0]   grp,
  input  logic [32*NREG-1:0]   grp_mod,
  output logic [32*NREG-1:0]   nmi_out
);
  localparam int NINT = 32 * NREG;

  logic [NINT-1:0] flags, elig, acc;
  logic [NREG-1:0] hit;
  logic [31:0]     rd_word;
  logic [9:0]      impl_lim;

  assign impl_lim = {1'b0, impl_cnt, 5'd0};

  for (genvar i = 0; i < NINT; i++) begin : g_bit
    logic sec_int, grp0, aff, impl;
    assign sec_int = !sec_dis && !grp[i];
    assign grp0    = !grp[i] && (sec_dis || !grp_mod[i]);
    assign aff     = (sec_dis || !grp[i]) ? aff_en_s : aff_en_ns;
    assign impl    = feat_en && (10'(i) < impl_lim);
    assign elig[i] = impl && !grp0 && aff;
    assign acc[i]  = elig[i] && (bus_secure || !sec_int);
  end

  for (genvar k = 0; k < NREG; k++) begin : g_word
    assign hit[k] = bus_addr[AW-1:2] == BASE_ADDR[AW-1:2] + (AW-2)'(k);

    always_ff @(posedge clk) begin
      if (!rst_n)
        flags[32*k +: 32] <= '0;
      else if (bus_wr && hit[k])
        flags[32*k +: 32] <= (flags[32*k +: 32] & ~acc[32*k +: 32])
                           | (bus_wdata & acc[32*k +: 32]);
    end
  end

  always_comb begin
    rd_word = '0;
    for (int k = 0; k < NREG; k++)
      if (hit[k]) rd_word = rd_word | (flags[32*k +: 32] & acc[32*k +: 32]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= bus_rd ? rd_word : '0;
  end

  assign nmi_out = flags & elig;
endmodule

// File: rtl/nmi_prop_regs_chk.sv
module nmi_prop_regs_chk #(
  parameter int NINT = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_wr,
  input logic            bus_rd,
  input logic [31:0]     rd_data,
  input logic            feat_en,
  input logic [3:0]      impl_cnt,
  input logic            sec_dis,
  input logic            aff_en_s,
  input logic            aff_en_ns,
  input logic [NINT-1:0] grp,
  input logic [NINT-1:0] grp_mod,
  input logic [NINT-1:0] nmi_out
);
  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (nmi_out == '0 && rd_data == '0)); // R1
  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !bus_rd |=> rd_data == '0); // R3
  AST_FEAT_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !feat_en |-> nmi_out == '0); // R4
  AST_NONE_IMPL_QUIET: assert property (@(posedge clk) disable iff (!rst_n) impl_cnt == 4'd0 |-> nmi_out == '0); // R5
  AST_GROUP0_NEVER_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_out & ~grp & (~grp_mod | {NINT{sec_dis}})) == '0); // R6
  AST_ROUTING_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!aff_en_s && !aff_en_ns) |-> nmi_out == '0); // R8
  AST_OUT_HOLDS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!bus_wr) && $stable(grp) && $stable(grp_mod) && $stable(feat_en) && $stable(impl_cnt)
     && $stable(sec_dis) && $stable(aff_en_s) && $stable(aff_en_ns)) |-> $stable(nmi_out)); // R9
endmodule

bind nmi_prop_regs nmi_prop_regs_chk #(.NINT(32*NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .rd_data(rd_data),
  .feat_en(feat_en), .impl_cnt(impl_cnt), .sec_dis(sec_dis), .aff_en_s(aff_en_s),
  .aff_en_ns(aff_en_ns), .grp(grp), .grp_mod(grp_mod), .nmi_out(nmi_out)
);

// File: tb/nmi_prop_regs_bench.sv
module nmi_prop_regs_bench;
  logic        clk = 0, rst_n = 0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 0, bus_rd = 0, bus_secure = 0;
  logic [31:0] bus_wdata = '0, rd_data;
  logic        feat_en = 1, sec_dis = 0, aff_en_s = 1, aff_en_ns = 1;
  logic [3:0]  impl_cnt = 4'd2;
  logic [63:0] grp = '1, grp_mod = '0, nmi_out;

  int n_chk = 0, n_bad = 0;
  logic rd_seen = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  localparam logic [11:0] R0 = 12'hF80, R1A = 12'hF84;

  always #5 clk = ~clk;

  nmi_prop_regs u_nmi_prop_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_secure(bus_secure), .rd_data(rd_data),
    .feat_en(feat_en), .impl_cnt(impl_cnt), .sec_dis(sec_dis), .aff_en_s(aff_en_s),
    .aff_en_ns(aff_en_ns), .grp(grp), .grp_mod(grp_mod), .nmi_out(nmi_out)
  );

  always @(posedge clk) rd_seen <= bus_rd;

  always @(negedge clk) begin
    if (rd_seen) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R3: unexpected read result %h, expected none", rd_data);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          n_bad++;
          $display("FAIL %s: read %h expected %h", t, rd_data, e);
        end
      end
    end else if (rst_n && rd_data !== '0) begin
      n_chk++;
      n_bad++;
      $display("FAIL R3: idle rd_data %h expected 00000000", rd_data);
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic s);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_secure = s; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, input logic s, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_addr = a; bus_secure = s; bus_rd = 1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic rdwr(input logic [11:0] a, input logic [31:0] d, input logic s,
                      input logic [31:0] e, input string t);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_secure = s; bus_wr = 1; bus_rd = 1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_wr = 0; bus_rd = 0;
  endtask

  task automatic chk_out(input logic [63:0] e, input string t);
    @(negedge clk);
    n_chk++;
    if (nmi_out !== e) begin
      n_bad++;
      $display("FAIL %s: nmi_out %h expected %h", t, nmi_out, e);
    end
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_out(64'h0, "R1 in reset");
    rst_n = 1;
    rd(R0, 1, 32'h0, "R1 reset word0");
    chk_out(64'h0, "R1 reset out");

    wr(R0, 32'hFFFF_FFFF, 1);
    rd(R0, 0, 32'hFFFF_FFFF, "R2 word0");
    chk_out(64'h0000_0000_FFFF_FFFF, "R9 out after write");
    wr(R1A, 32'hA5A5_0F0F, 0);
    rd(R1A, 0, 32'hA5A5_0F0F, "R2 word1");
    chk_out(64'hA5A5_0F0F_FFFF_FFFF, "R2 out mapping");

    wr(R0, 32'h0, 1);
    grp[3:0] = 4'h0;
    wr(R0, 32'hFFFF_FFFF, 1);
    rd(R0, 1, 32'hFFFF_FFF0, "R6 group0 read");
    chk_out(64'hA5A5_0F0F_FFFF_FFF0, "R6 group0 out");
    grp[3:0] = 4'hF;
    rd(R0, 1, 32'hFFFF_FFF0, "R6 group0 not set");

    grp[11:8] = 4'h0; grp_mod[11:8] = 4'hF;
    rd(R0, 0, 32'hFFFF_F0F0, "R7 ns hides sg1");
    rd(R0, 1, 32'hFFFF_FFF0, "R7 secure sees sg1");
    wr(R0, 32'h0, 0);
    rd(R0, 1, 32'h0000_0F00, "R7 ns write ignored");
    chk_out(64'hA5A5_0F0F_0000_0F00, "R7 sg1 out");

    sec_dis = 1;
    rd(R0, 0, 32'h0, "R6 sec_dis makes group0");
    chk_out(64'hA5A5_0F0F_0000_0000, "R6 sec_dis out");
    sec_dis = 0;
    chk_out(64'hA5A5_0F0F_0000_0F00, "R9 flag reappears");

    aff_en_s = 0;
    rd(R0, 1, 32'h0, "R8 secure routing off");
    chk_out(64'hA5A5_0F0F_0000_0000, "R8 secure routing out");
    aff_en_s = 1;
    grp[11:8] = 4'hF; grp_mod[11:8] = 4'h0;
    aff_en_ns = 0;
    chk_out(64'h0, "R8 ns routing out");
    rd(R1A, 0, 32'h0, "R8 ns routing read");
    wr(R1A, 32'hFFFF_FFFF, 0);
    aff_en_ns = 1;
    rd(R1A, 0, 32'hA5A5_0F0F, "R8 write ignored");

    impl_cnt = 4'd1;
    chk_out(64'h0000_0000_0000_0F00, "R5 count one out");
    rd(R1A, 1, 32'h0, "R5 unimpl read");
    wr(R1A, 32'hFFFF_FFFF, 1);
    impl_cnt = 4'd2;
    rd(R1A, 1, 32'hA5A5_0F0F, "R5 unimpl write ignored");
    impl_cnt = 4'd0;
    rd(R0, 1, 32'h0, "R5 count zero read");
    chk_out(64'h0, "R5 count zero out");
    impl_cnt = 4'd2;

    feat_en = 0;
    rd(R0, 1, 32'h0, "R4 absent read");
    chk_out(64'h0, "R4 absent out");
    wr(R0, 32'hFFFF_FFFF, 1);
    feat_en = 1;
    rd(R0, 1, 32'h0000_0F00, "R4 write ignored");

    rd(12'hF88, 1, 32'h0, "R2 unmapped read");
    wr(12'hF88, 32'hFFFF_FFFF, 1);
    wr(12'hF7C, 32'hFFFF_FFFF, 1);
    rd(R0, 1, 32'h0000_0F00, "R2 unmapped write word0");
    rd(R1A, 1, 32'hA5A5_0F0F, "R2 unmapped write word1");
    rd(12'hF83, 1, 32'h0000_0F00, "R2 low bits ignored");

    rdwr(R0, 32'h1234_5678, 1, 32'h0000_0F00, "R3 read before write");
    rd(R0, 1, 32'h1234_5678, "R3 write landed");
    chk_out(64'hA5A5_0F0F_1234_5678, "R9 out follows write");

    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL R3: %0d reads unanswered, expected 0", exp_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule